// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to eight interrupt sources for a small 8-bit processor. It has one byte-wide write port and one byte-wide read port, selected by a chip select, a single address bit and separate read and write strobes. It drives one interrupt request line and answers a three-cycle interrupt acknowledge. Each input is captured on its rising edge. Software can mask each input on its own. The pending, unmasked input with the best fixed priority wins. During acknowledge the block returns a call instruction whose target address is built from a base set at initialization and the number of the winning input.

Software first writes two initialization words. The first, written with the address bit low and data bit 4 set, provides the top three bits of the low vector byte. The second provides the high vector byte. After that, writes with the address bit high load the mask, and writes with the address bit low send end-of-interrupt commands. An in-service record keeps requests of equal or lower priority waiting until software retires the running handler.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `int_req` is 0, `dout` is 00H, and the controller counts as uninitialized.
- R2: A write with `a0`=0 and `wdata[4]`=1 is the first setup word: `wdata[7:5]` becomes bits 7:5 of the low vector byte, and the mask, in-service and pending state are cleared. The next write with `a0`=1 is the second setup word and becomes the high vector byte. `int_req` stays 0 until both words have been written.
- R3: A request is recorded on a 0-to-1 change of `irq_in[n]` and stays pending until an acknowledge takes it. An input held high after it was taken does not request again until it falls and rises once more.
- R4: After setup, a write with `a0`=1 loads the mask. Mask bit n = 1 blocks input n from `int_req`; a blocked request stays pending and raises `int_req` once its mask bit is cleared.
- R5: Input 0 has the highest priority and input 7 the lowest. The winner is the lowest-numbered pending, unmasked, allowed input.
- R6: Three `int_ack` pulses return, on `dout` in the cycle after each pulse, first CDH, then the low byte {base[7:5], winner number (3 bits), 00}, then the high vector byte.
- R7: The first acknowledge pulse sets the winner's in-service bit and clears its pending bit.
- R8: While an in-service bit is set, only inputs with a strictly lower number (higher priority) can raise `int_req`.
- R9: A write with `a0`=0, `wdata[4]`=0 and `wdata[5]`=1 after setup clears the lowest-numbered set in-service bit.
- R10: A read strobe puts the mask (`a0`=1) or the in-service bits (`a0`=0) on `dout` in the next cycle.
- R11: An acknowledge with no eligible request returns the vector for input 7 and sets no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| a0 | input | 1 | Register address bit |
| wr_stb | input | 1 | Write strobe, one cycle per write |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| wdata | input | 8 | Write data |
| irq_in | input | 8 | Interrupt sources, rising-edge sensitive |
| int_ack | input | 1 | Acknowledge pulse, three per interrupt |
| int_req | output | 1 | Interrupt request to the processor |
| dout | output | 8 | Registered read and vector data |

## Verification
The main function is tested with a set of cases. Each case sets a different vector base, mask and group of simultaneous edges. One case has a single enabled input. One has inputs 0 and 7 active together, which shows that input 0 wins. One masks input 0 while inputs 0 and 3 are active, so the mask must outrank priority. One has only input 7 active, to check the input-number field and its upper end. One has every input masked, which gives the default vector. One masks inputs 0 to 3 while inputs 4 and 5 are active. The directed tests check nesting: a lower and an equal request are held off while a handler runs, and a higher one gets through. They also check that end-of-interrupt clears handlers in priority order, that a held-high input does not request again, that a masked request is kept, and that the request line stays silent during setup.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared constants, setup state type and bit helpers for the
// vectored interrupt controller. Assumes at most 8 inputs (3-bit number field).
package irq_ctrl_pkg;
    localparam logic [7:0] CALL_OPCODE = 8'hCD;

    typedef enum logic [1:0] {
        CFG_IDLE  = 2'd0,
        CFG_WAIT2 = 2'd1,
        CFG_RUN   = 2'd2
    } cfg_state_t;

    // Isolate the lowest set bit of an 8-bit vector (zero stays zero).
    function automatic logic [7:0] low_bit8(input logic [7:0] v);
        return v & (~v + 8'd1);
    endfunction
endpackage

// File: rtl/irq_edge_latch.sv
// Edge capture: records 0-to-1 changes on each input as pending requests.
// Assumes inputs are already synchronous to clk. A bulk clear wins over
// everything; a new edge wins over the acknowledge clear of the same bit.
module irq_edge_latch #(
    parameter int N_IN = 8,
    localparam int IW  = $clog2(N_IN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_all,
    input  logic [N_IN-1:0] irq_in,
    input  logic            take,
    input  logic [IW-1:0]   take_idx,
    output logic [N_IN-1:0] pending
);
    logic [N_IN-1:0] prev_q;
    logic [N_IN-1:0] rise;
    logic [N_IN-1:0] take_vec;

    // Edge detect and the bit taken by the acknowledge.
    always_comb begin
        rise     = irq_in & ~prev_q;
        take_vec = take ? (N_IN'(1) << take_idx) : '0;
    end

    // Keep the previous input sample and update the pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            pending <= '0;
        end else begin
            prev_q <= irq_in;
            if (clr_all) pending <= '0;
            else         pending <= (pending & ~take_vec) | rise;
        end
    end

    generate
        for (genvar g = 0; g < N_IN; g++) begin : g_chk
            // R3
            edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_in[g] && !prev_q[g] && !clr_all) |=> pending[g]);
        end
    endgenerate
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority picker: finds the lowest-numbered set bit of req.
// Combinational only; idx is 0 when nothing is set.
module irq_prio_pick #(
    parameter int N_IN = 8,
    localparam int IW  = $clog2(N_IN)
) (
    input  logic [N_IN-1:0] req,
    output logic            found,
    output logic [IW-1:0]   idx
);
    // Scan from the lowest priority up so the best bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    // Check that the pick has no better-ranked bit below it.
    always_comb begin
        // R5
        if (found) begin
            prio_pick_chk: assert (req[idx] && ((req & ((N_IN'(1) << idx) - N_IN'(1))) == '0));
        end
    end
endmodule

// File: rtl/irq_ack_seq.sv
// Acknowledge sequencer: steps through opcode, low vector byte and high
// vector byte over three ack pulses. Latches the winner on the first pulse;
// with no winner it uses the last input number. Assumes 8 inputs.
module irq_ack_seq #(
    parameter int N_IN = 8,
    localparam int IW  = $clog2(N_IN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          ack,
    input  logic          found,
    input  logic [IW-1:0] win_idx,
    input  logic [2:0]    base_top,
    input  logic [7:0]    base_hi,
    output logic          take,
    output logic          first_phase,
    output logic [7:0]    ack_byte
);
    import irq_ctrl_pkg::*;

    logic [1:0]    phase_q;
    logic [IW-1:0] idx_q;

    assign first_phase = (phase_q == 2'd0);
    assign take        = ack && first_phase && found;

    // Advance the phase on each ack and latch the number used for the vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 2'd0;
            idx_q   <= '0;
        end else if (restart) begin
            phase_q <= 2'd0;
        end else if (ack) begin
            phase_q <= (phase_q == 2'd2) ? 2'd0 : phase_q + 2'd1;
            if (first_phase) idx_q <= found ? win_idx : IW'(N_IN - 1);
        end
    end

    // Select the byte for the current phase.
    always_comb begin
        case (phase_q)
            2'd0:    ack_byte = CALL_OPCODE;
            2'd1:    ack_byte = 8'({base_top, idx_q, 2'b00});
            default: ack_byte = base_hi;
        endcase
    end

    // R6
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q != 2'd3);
endmodule

// File: rtl/vec_irq_ctrl.sv
// Top: eight-input vectored interrupt controller. Holds the setup words,
// the mask and the in-service record, gates requests by priority and
// drives registered data for reads and acknowledge cycles.
// Assumes single-cycle strobes synchronous to clk and edge-only inputs.
module vec_irq_ctrl #(
    parameter int N_IN = 8,
    localparam int IW  = $clog2(N_IN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs,
    input  logic            a0,
    input  logic            wr_stb,
    input  logic            rd_stb,
    input  logic [7:0]      wdata,
    input  logic [N_IN-1:0] irq_in,
    input  logic            int_ack,
    output logic            int_req,
    output logic [7:0]      dout
);
    import irq_ctrl_pkg::*;

    cfg_state_t      cfg_q;
    logic [2:0]      base_top_q;
    logic [7:0]      base_hi_q;
    logic [N_IN-1:0] mask_q;
    logic [N_IN-1:0] isr_q;
    logic [N_IN-1:0] pending;
    logic [N_IN-1:0] allowed;
    logic [N_IN-1:0] eligible;
    logic [N_IN-1:0] isr_low;
    logic [N_IN-1:0] isr_set;
    logic            win_found;
    logic [IW-1:0]   win_idx;
    logic            take;
    logic            first_phase;
    logic [7:0]      ack_byte;
    logic            wr, setup1_wr, setup2_wr, mask_wr, eoi_wr;

    // Decode bus writes by address bit, data bit 4 and setup state.
    always_comb begin
        wr        = cs && wr_stb;
        setup1_wr = wr && !a0 && wdata[4];
        setup2_wr = wr && a0 && (cfg_q == CFG_WAIT2);
        mask_wr   = wr && a0 && (cfg_q == CFG_RUN);
        eoi_wr    = wr && !a0 && !wdata[4] && wdata[5] && (cfg_q == CFG_RUN);
    end

    // Priority gating: only inputs better than the best in-service one pass.
    always_comb begin
        isr_low  = N_IN'(low_bit8(8'(isr_q)));
        allowed  = isr_low - N_IN'(1);
        eligible = pending & ~mask_q & allowed;
        int_req  = (cfg_q == CFG_RUN) && (eligible != '0);
        isr_set  = take ? (N_IN'(1) << win_idx) : '0;
    end

    irq_edge_latch #(.N_IN(N_IN)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (setup1_wr),
        .irq_in   (irq_in),
        .take     (take),
        .take_idx (win_idx),
        .pending  (pending)
    );

    irq_prio_pick #(.N_IN(N_IN)) u_pick (
        .req   (eligible),
        .found (win_found),
        .idx   (win_idx)
    );

    irq_ack_seq #(.N_IN(N_IN)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (setup1_wr),
        .ack         (int_ack),
        .found       (win_found),
        .win_idx     (win_idx),
        .base_top    (base_top_q),
        .base_hi     (base_hi_q),
        .take        (take),
        .first_phase (first_phase),
        .ack_byte    (ack_byte)
    );

    // Setup sequence and the vector base registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q      <= CFG_IDLE;
            base_top_q <= '0;
            base_hi_q  <= '0;
        end else if (setup1_wr) begin
            cfg_q      <= CFG_WAIT2;
            base_top_q <= wdata[7:5];
        end else if (setup2_wr) begin
            cfg_q     <= CFG_RUN;
            base_hi_q <= wdata;
        end
    end

    // Mask register: cleared by the first setup word, loaded after setup.
    always_ff @(posedge clk) begin
        if (!rst_n || setup1_wr) mask_q <= '0;
        else if (mask_wr)        mask_q <= wdata[N_IN-1:0];
    end

    // In-service record: set on the first ack, lowest bit cleared by EOI.
    always_ff @(posedge clk) begin
        if (!rst_n || setup1_wr) isr_q <= '0;
        else isr_q <= (isr_q & ~(eoi_wr ? isr_low : '0)) | isr_set;
    end

    // Output data: ack bytes take precedence over register reads.
    always_ff @(posedge clk) begin
        if (!rst_n)              dout <= 8'h00;
        else if (int_ack)        dout <= ack_byte;
        else if (cs && rd_stb)   dout <= a0 ? 8'(mask_q) : 8'(isr_q);
    end

    // R2
    req_needs_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (cfg_q == CFG_RUN));

    // R4
    req_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> ((pending & ~mask_q) != '0));

    // R6
    ack_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && first_phase && !setup1_wr) |=> (dout == CALL_OPCODE));

    // R7
    isr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !setup1_wr) |=> isr_q[$past(win_idx)]);

    // R9
    eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !take && (isr_q != '0)) |=>
            ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: tb/tb_vec_irq_ctrl.sv
// Testbench: a table of setup/mask/edge cases walked by one loop, then
// directed tests for reset, setup, masking, nesting, EOI and reads.
module tb_vec_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, a0 = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] irq_in = 8'h00;
    logic       int_ack = 1'b0;
    logic       int_req;
    logic [7:0] dout;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vec_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .a0(a0), .wr_stb(wr_stb),
        .rd_stb(rd_stb), .wdata(wdata), .irq_in(irq_in), .int_ack(int_ack),
        .int_req(int_req), .dout(dout)
    );

    // Fields: setup1, setup2, mask, edges, expected req, low byte, high byte.
    localparam logic [55:0] CASES [6] = '{
        {8'h76, 8'h20, 8'hFD, 8'h02, 8'h01, 8'h64, 8'h20},
        {8'h76, 8'h20, 8'h00, 8'h81, 8'h01, 8'h60, 8'h20},
        {8'hF6, 8'h3A, 8'h01, 8'h09, 8'h01, 8'hEC, 8'h3A},
        {8'h16, 8'h40, 8'h00, 8'h80, 8'h01, 8'h1C, 8'h40},
        {8'hB6, 8'h10, 8'hFF, 8'h10, 8'h00, 8'hBC, 8'h10},
        {8'h56, 8'h00, 8'h0F, 8'h30, 8'h01, 8'h50, 8'h00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic adr, input logic [7:0] d);
        cs = 1'b1; a0 = adr; wr_stb = 1'b1; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr_stb = 1'b0;
    endtask

    task automatic bus_rd(input logic adr, output logic [7:0] v);
        cs = 1'b1; a0 = adr; rd_stb = 1'b1;
        @(negedge clk);
        cs = 1'b0; rd_stb = 1'b0;
        v = dout;
    endtask

    task automatic ack(output logic [7:0] v);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
        v = dout;
    endtask

    task automatic set_irq(input logic [7:0] v);
        irq_in = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 int_req after reset", {7'd0, int_req}, 8'h00);
        chk("R1 dout after reset", dout, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        set_irq(8'h01);
        chk("R1 no request before setup", {7'd0, int_req}, 8'h00);
        set_irq(8'h00);

        // Table walk: R2 R4 R5 R6 R11
        for (int k = 0; k < 6; k++) begin
            logic [55:0] e;
            e = CASES[k];
            bus_wr(1'b0, e[55:48]);
            bus_wr(1'b1, e[47:40]);
            bus_wr(1'b1, e[39:32]);
            set_irq(e[31:24]);
            set_irq(8'h00);
            chk($sformatf("R5 R4 case %0d int_req", k), {7'd0, int_req}, e[23:16]);
            ack(v); chk($sformatf("R6 case %0d opcode", k), v, 8'hCD);
            ack(v); chk($sformatf("R6 R11 case %0d low byte", k), v, e[15:8]);
            ack(v); chk($sformatf("R6 case %0d high byte", k), v, e[7:0]);
        end

        // R2: request waits for the second setup word
        bus_wr(1'b0, 8'h76);
        set_irq(8'h04);
        chk("R2 held between setup words", {7'd0, int_req}, 8'h00);
        bus_wr(1'b1, 8'h20);
        chk("R2 released after second word", {7'd0, int_req}, 8'h01);
        // R3: level held after ack does not request again
        ack(v); ack(v);
        chk("R3 low byte for input 2", v, 8'h68);
        ack(v);
        bus_wr(1'b0, 8'h20);
        chk("R3 held level no re-request", {7'd0, int_req}, 8'h00);
        set_irq(8'h00);
        set_irq(8'h04);
        chk("R3 new edge requests", {7'd0, int_req}, 8'h01);
        set_irq(8'h00);

        // R4: masked request is kept
        bus_wr(1'b0, 8'h76); bus_wr(1'b1, 8'h20);
        bus_wr(1'b1, 8'h04);
        set_irq(8'h04); set_irq(8'h00);
        chk("R4 masked input silent", {7'd0, int_req}, 8'h00);
        bus_wr(1'b1, 8'h00);
        chk("R4 unmask raises kept request", {7'd0, int_req}, 8'h01);

        // R7 R8 R9: nesting
        bus_wr(1'b0, 8'h76); bus_wr(1'b1, 8'h20);
        set_irq(8'h08); set_irq(8'h00);
        ack(v); ack(v); ack(v);
        bus_rd(1'b0, v);
        chk("R7 in-service bit 3", v, 8'h08);
        chk("R7 pending cleared, no request", {7'd0, int_req}, 8'h00);
        set_irq(8'h20); set_irq(8'h00);
        chk("R8 lower priority held", {7'd0, int_req}, 8'h00);
        set_irq(8'h08); set_irq(8'h00);
        chk("R8 equal priority held", {7'd0, int_req}, 8'h00);
        set_irq(8'h02); set_irq(8'h00);
        chk("R8 higher priority passes", {7'd0, int_req}, 8'h01);
        ack(v); ack(v);
        chk("R8 nested low byte input 1", v, 8'h64);
        ack(v);
        bus_rd(1'b0, v);
        chk("R7 two in service", v, 8'h0A);
        bus_wr(1'b0, 8'h20);
        bus_rd(1'b0, v);
        chk("R9 EOI clears best bit", v, 8'h08);
        chk("R9 input 3 still blocks", {7'd0, int_req}, 8'h00);
        bus_wr(1'b0, 8'h20);
        bus_rd(1'b0, v);
        chk("R9 second EOI empties", v, 8'h00);
        chk("R9 kept requests resume", {7'd0, int_req}, 8'h01);
        ack(v); ack(v);
        chk("R5 input 3 before 5", v, 8'h6C);
        ack(v);

        // R10: read back mask
        bus_wr(1'b1, 8'hA5);
        bus_rd(1'b1, v);
        chk("R10 mask readback", v, 8'hA5);

        // R11: spurious ack sets nothing
        bus_wr(1'b0, 8'h76); bus_wr(1'b1, 8'h20);
        ack(v); ack(v);
        chk("R11 default low byte", v, 8'h7C);
        ack(v);
        bus_rd(1'b0, v);
        chk("R11 no in-service bit", v, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule